// File: doc/BRIEF.md
# Authenticated Scan Data Register

This block is a test-port data register whose contents reach the rest of the chip only when the scanned frame carries a correct authentication tag. Each scan frame is a payload of `PAYLOAD_W` bits followed by a tag of `TAG_W` bits, arriving on the already-decrypted serial data input. During the shift a keyed checksum is folded over the payload one bit per clock, so the expected tag is ready as soon as the last payload bit has arrived. The received tag bits are collected apart from the payload and never enter the checksum.

When the port leaves the shift state, the block compares the received tag with the computed one and checks the frame length. On a match it copies the payload into a separate held register and raises a valid flag. On a mismatch the held register keeps its old value, the valid flag drops and a sticky error flag is set. Only a party that holds the MAC key can make new contents appear on the held register. The key is supplied from outside and is sampled at the start of each scan.

Top module: `mac_gated_dr`

## Requirements
- R1: After reset `data_o` is all zeros and `valid_o` and `err_o` are 0.
- R2: On a capture strobe the checksum state is loaded with the low `TAG_W` bits of `mac_key_i`, and the high `TAG_W` bits are held as a mask. For each payload bit b, in arrival order, with state s: fb = s[TAG_W-1] ^ b, and s becomes (s << 1) ^ (fb ? (POLY ^ mask) : 0).
- R3: The first `PAYLOAD_W` shifted bits are the payload, and the first of them lands in `data_o` bit 0. The next `TAG_W` bits are the tag, and the first of them is tag bit 0.
- R4: An exit strobe after exactly `PAYLOAD_W+TAG_W` shifted bits, with the tag equal to the final checksum, sets `data_o` to the payload and `valid_o` to 1 on the clock edge that samples the strobe. `err_o` is left unchanged.
- R5: An exit strobe with a tag that differs from the checksum leaves `data_o` unchanged, clears `valid_o` and sets `err_o`.
- R6: A scan with one bit fewer or one bit more than `PAYLOAD_W+TAG_W` is rejected as in R5, even when its tag bits are correct.
- R7: `err_o` stays set until reset, including through later passing scans, which still set `valid_o`.
- R8: Capture, shift and exit strobes have no effect while `sel_i` is 0.
- R9: Changes to `mac_key_i` after the capture strobe do not affect the verdict of the scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | This data register is selected by the current instruction |
| capture_i | input | 1 | Capture state strobe, start of scan |
| shift_i | input | 1 | Shift state, one bit per clock |
| exit_i | input | 1 | Leaving the shift state, triggers the verdict |
| tdi_i | input | 1 | Decrypted serial data bit |
| mac_key_i | input | 2*TAG_W | MAC key: low half is the seed, high half is the mask |
| data_o | output | PAYLOAD_W | Held, authenticated payload |
| valid_o | output | 1 | Held payload came from an authenticated scan |
| err_o | output | 1 | Sticky authentication failure |

## Verification
The bench builds the block with an 8-bit payload, a 4-bit tag and polynomial 0x3. With these values every one of the 256 payloads can be scanned with its correct tag under two different keys. The same settings also allow a flip of each single tag bit, frames that are one bit short and one bit long, a key change in the middle of a scan, and scans with the register deselected. Expected tags come from an arithmetic model of the keyed shift rule in R2, written inside the bench.

// File: rtl/mvdr_pkg.sv
package mvdr_pkg;
  typedef enum logic [1:0] {
    VERD_IDLE = 2'd0,
    VERD_PASS = 2'd1,
    VERD_FAIL = 2'd2
  } verdict_e;

  typedef struct packed {
    logic capture;
    logic shift;
    logic exit;
  } strobe_t;
endpackage

// File: rtl/mvdr_keyed_lfsr.sv
module mvdr_keyed_lfsr #(
  parameter int unsigned TAG_W = 16,
  parameter logic [TAG_W-1:0] POLY = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAG_W-1:0] seed_i,
  input  logic [TAG_W-1:0] mask_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [TAG_W-1:0] sum_o
);
  logic [TAG_W-1:0] state_q, mask_q, taps;
  logic             fb;

  assign fb   = state_q[TAG_W-1] ^ bit_i;
  assign taps = POLY ^ mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      mask_q  <= '0;
    end else if (load_i) begin
      state_q <= seed_i;
      mask_q  <= mask_i;
    end else if (step_i) begin
      state_q <= {state_q[TAG_W-2:0], 1'b0} ^ (fb ? taps : '0);
    end
  end

  assign sum_o = state_q;
endmodule

// File: rtl/mvdr_frame_rx.sv
module mvdr_frame_rx #(
  parameter int unsigned PAYLOAD_W = 32,
  parameter int unsigned TAG_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [PAYLOAD_W-1:0] payload_o,
  output logic [TAG_W-1:0]     tag_o,
  output logic                 in_payload_o,
  output logic                 len_ok_o
);
  localparam int unsigned FRAME_W = PAYLOAD_W + TAG_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_PAY  = CNT_W'(PAYLOAD_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [PAYLOAD_W-1:0] pay_q;
  logic [TAG_W-1:0]     tag_q;
  logic                 in_tag;

  assign in_payload_o = shift_i && (cnt_q < CNT_PAY);
  assign in_tag       = shift_i && (cnt_q >= CNT_PAY) && (cnt_q < CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pay_q <= '0;
      tag_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      tag_q <= '0;
    end else if (shift_i) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (in_payload_o) pay_q <= {bit_i, pay_q[PAYLOAD_W-1:1]};
      if (in_tag)       tag_q <= {bit_i, tag_q[TAG_W-1:1]};
    end
  end

  assign payload_o = pay_q;
  assign tag_o     = tag_q;
  assign len_ok_o  = (cnt_q == CNT_FULL);
endmodule

// File: rtl/mvdr_verdict.sv
module mvdr_verdict
  import mvdr_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 32,
  parameter int unsigned TAG_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 eval_i,
  input  logic                 len_ok_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [TAG_W-1:0]     sum_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic [PAYLOAD_W-1:0] data_o,
  output logic                 valid_o,
  output logic                 err_o
);
  verdict_e             verdict;
  logic [PAYLOAD_W-1:0] data_q;
  logic                 valid_q, err_q;

  always_comb begin
    verdict = VERD_IDLE;
    if (eval_i) verdict = (len_ok_i && (tag_i == sum_i)) ? VERD_PASS : VERD_FAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (verdict)
        VERD_PASS: begin
          data_q  <= payload_i;
          valid_q <= 1'b1;
        end
        VERD_FAIL: begin
          valid_q <= 1'b0;
          err_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mac_gated_dr.sv
module mac_gated_dr
  import mvdr_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 32,
  parameter int unsigned TAG_W     = 16,
  parameter logic [TAG_W-1:0] POLY = TAG_W'(16'h1021)
) (
  input  logic                 tck_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 capture_i,
  input  logic                 shift_i,
  input  logic                 exit_i,
  input  logic                 tdi_i,
  input  logic [2*TAG_W-1:0]   mac_key_i,
  output logic [PAYLOAD_W-1:0] data_o,
  output logic                 valid_o,
  output logic                 err_o
);
  strobe_t              stb;
  logic [PAYLOAD_W-1:0] payload;
  logic [TAG_W-1:0]     tag, sum;
  logic                 in_payload, len_ok;

  assign stb.capture = sel_i && capture_i;
  assign stb.shift   = sel_i && shift_i && !capture_i;
  assign stb.exit    = sel_i && exit_i && !capture_i && !shift_i;

  mvdr_frame_rx #(.PAYLOAD_W(PAYLOAD_W), .TAG_W(TAG_W)) u_rx (
    .clk_i       (tck_i),
    .rst_ni      (rst_ni),
    .load_i      (stb.capture),
    .shift_i     (stb.shift),
    .bit_i       (tdi_i),
    .payload_o   (payload),
    .tag_o       (tag),
    .in_payload_o(in_payload),
    .len_ok_o    (len_ok)
  );

  mvdr_keyed_lfsr #(.TAG_W(TAG_W), .POLY(POLY)) u_mac (
    .clk_i (tck_i),
    .rst_ni(rst_ni),
    .load_i(stb.capture),
    .seed_i(mac_key_i[TAG_W-1:0]),
    .mask_i(mac_key_i[2*TAG_W-1:TAG_W]),
    .step_i(in_payload),
    .bit_i (tdi_i),
    .sum_o (sum)
  );

  mvdr_verdict #(.PAYLOAD_W(PAYLOAD_W), .TAG_W(TAG_W)) u_vd (
    .clk_i    (tck_i),
    .rst_ni   (rst_ni),
    .eval_i   (stb.exit),
    .len_ok_i (len_ok),
    .tag_i    (tag),
    .sum_i    (sum),
    .payload_i(payload),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/mac_gated_dr_chk.sv
module mac_gated_dr_chk #(
  parameter int unsigned PAYLOAD_W = 32
) (
  input logic                 tck_i,
  input logic                 rst_ni,
  input logic                 sel_i,
  input logic                 capture_i,
  input logic                 shift_i,
  input logic                 exit_i,
  input logic [PAYLOAD_W-1:0] data_o,
  input logic                 valid_o,
  input logic                 err_o
);
  logic exit_sel;
  assign exit_sel = sel_i && exit_i && !capture_i && !shift_i;

  assert_valid_only_on_exit_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(exit_sel));

  assert_data_only_on_pass_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(data_o) |-> ($past(exit_sel) && valid_o));

  assert_err_sticky_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_exit_gives_verdict_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    exit_sel |=> (valid_o || err_o));

  assert_fail_drops_valid_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(err_o) |-> !valid_o);

  assert_deselect_inert_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !sel_i |=> ($stable(data_o) && $stable(valid_o) && $stable(err_o)));
endmodule

bind mac_gated_dr mac_gated_dr_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .tck_i    (tck_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .capture_i(capture_i),
  .shift_i  (shift_i),
  .exit_i   (exit_i),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .err_o    (err_o)
);

// File: tb/sim_mac_gated_dr.sv
`timescale 1ns/1ps
module sim_mac_gated_dr;
  localparam int unsigned P = 8;
  localparam int unsigned T = 4;
  localparam logic [T-1:0] PL = 4'h3;

  logic         tck = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sel_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, exit_i = 1'b0, tdi_i = 1'b0;
  logic [2*T-1:0] mac_key_i = '0;
  logic [P-1:0] data_o;
  logic         valid_o, err_o;

  int vecs = 0, errs = 0;
  bit finished = 0;

  always #10 tck = ~tck;

  mac_gated_dr #(.PAYLOAD_W(P), .TAG_W(T), .POLY(PL)) u0 (
    .tck_i(tck), .rst_ni(rst_ni), .sel_i(sel_i), .capture_i(capture_i),
    .shift_i(shift_i), .exit_i(exit_i), .tdi_i(tdi_i), .mac_key_i(mac_key_i),
    .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
  );

  function automatic logic [T-1:0] mac_of(input logic [P-1:0] pay, input logic [2*T-1:0] key);
    logic [T-1:0] s = key[T-1:0];
    logic [T-1:0] m = key[2*T-1:T];
    for (int i = 0; i < P; i++) begin
      logic fb = s[T-1] ^ pay[i];
      s = (s << 1) ^ (fb ? (PL ^ m) : '0);
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [P-1:0] d, input logic v, input logic e);
    vecs++;
    if (data_o !== d || valid_o !== v || err_o !== e) begin
      errs++;
      $display("FAIL %s: data=%h valid=%b err=%b expected data=%h valid=%b err=%b",
               req, data_o, valid_o, err_o, d, v, e);
    end
  endtask

  task automatic do_reset();
    @(negedge tck); rst_ni = 1'b0;
    repeat (2) @(negedge tck);
    rst_ni = 1'b1;
  endtask

  // nbits total bits from {tag,payload}; extra bits beyond P+T are zeros
  task automatic scan(input logic [P-1:0] pay, input logic [T-1:0] tg, input int nbits,
                      input logic [2*T-1:0] key_mid, input bit swap_key);
    logic [P+T-1:0] fr = {tg, pay};
    @(negedge tck); capture_i = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge tck);
      capture_i = 1'b0; shift_i = 1'b1;
      tdi_i = (i < P + T) ? fr[i] : 1'b0;
      if (swap_key && i == 2) mac_key_i = key_mid;
    end
    @(negedge tck); shift_i = 1'b0; exit_i = 1'b1;
    @(negedge tck); exit_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [2*T-1:0] ka = 8'hA5, kb = 8'h3C;
    logic [P-1:0] last;
    do_reset();
    @(negedge tck);
    check("R1 reset", '0, 1'b0, 1'b0);
    sel_i = 1'b1;

    // R2 R3 R4: full payload sweep under two keys
    for (int k = 0; k < 2; k++) begin
      mac_key_i = (k == 0) ? ka : kb;
      for (int p = 0; p < 256; p++) begin
        scan(P'(p), mac_of(P'(p), mac_key_i), P + T, '0, 0);
        check("R4 pass sweep", P'(p), 1'b1, 1'b0);
      end
    end
    last = 8'hFF;

    // R5: single tag bit flips
    mac_key_i = ka;
    for (int p = 0; p < 256; p += 37) begin
      for (int b = 0; b < T; b++) begin
        scan(P'(p), mac_of(P'(p), ka) ^ T'(1 << b), P + T, '0, 0);
        check("R5 tag flip", last, 1'b0, 1'b1);
      end
    end

    // R7: pass after error keeps err
    scan(8'h5A, mac_of(8'h5A, ka), P + T, '0, 0);
    check("R7 pass after error", 8'h5A, 1'b1, 1'b1);

    // R6: length errors after reset
    do_reset(); sel_i = 1'b1;
    scan(8'h11, mac_of(8'h11, ka), P + T, '0, 0);
    check("R3 frame order", 8'h11, 1'b1, 1'b0);
    scan(8'h22, mac_of(8'h22, ka), P + T - 1, '0, 0);
    check("R6 short frame", 8'h11, 1'b0, 1'b1);
    do_reset(); sel_i = 1'b1;
    scan(8'h33, mac_of(8'h33, ka), P + T + 1, '0, 0);
    check("R6 long frame", 8'h00, 1'b0, 1'b1);

    // R8: deselected strobes ignored
    do_reset(); sel_i = 1'b1;
    scan(8'h44, mac_of(8'h44, ka), P + T, '0, 0);
    check("R8 setup", 8'h44, 1'b1, 1'b0);
    sel_i = 1'b0;
    scan(8'h55, mac_of(8'h55, ka), P + T, '0, 0);
    check("R8 deselected valid frame", 8'h44, 1'b1, 1'b0);
    scan(8'h66, 4'h0, P + T - 3, '0, 0);
    check("R8 deselected bad frame", 8'h44, 1'b1, 1'b0);

    // R9: key swap mid-scan
    sel_i = 1'b1; mac_key_i = ka;
    scan(8'h77, mac_of(8'h77, ka), P + T, kb, 1);
    check("R9 key swap mid-scan", 8'h77, 1'b1, 1'b0);
    mac_key_i = kb;
    scan(8'h88, mac_of(8'h88, kb), P + T, '0, 0);
    check("R2 new key next scan", 8'h88, 1'b1, 1'b0);

    do_reset();
    @(negedge tck);
    check("R1 reset after use", '0, 1'b0, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule